// File: doc/BRIEF.md
# Conversion Result Averaging and Threshold Gate

This block is the digital back end behind a successive-approximation converter core. Each raw code arrives with a valid strobe. In 12-bit mode the upper code bits are masked off, and in 16-bit mode the whole code is used. A signed calibration offset is then subtracted. The difference is clamped to the legal range of the selected mode.

Corrected samples are summed in groups of 1, 4, 8, 16 or 32. Each group total is rounded to the nearest integer and divided by a right shift to give one averaged result. An optional automatic compare then checks that result against two thresholds. When the compare is enabled, a result that meets the condition is delivered together with a hit flag. A result that fails the condition is dropped without a valid pulse.

A change of resolution or group size restarts the accumulation, so that no result mixes samples taken under two settings.

Top module: `sar_result_path`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `res_vld` and `cmp_hit` are low and `res_data` is zero.
- R2: With `cfg_res16`=0, bits 15:12 of `smp_code` have no effect. Every result fits in 12 bits and is presented zero-extended on `res_data`.
- R3: The corrected sample is the masked code minus the two's-complement `cal_offset`. A negative difference becomes 0.
- R4: A difference above full scale (4095 in 12-bit mode, 65535 in 16-bit mode) becomes full scale.
- R5: The `cfg_avg_sel` code selects the group size: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16 and 4 gives 32. Codes 5 to 7 behave as 1.
- R6: The result is (sum + N/2) >> log2(N) for a group of N samples, so a half rounds upward. For N=1 the result is the sample itself.
- R7: `res_vld` is a one-cycle pulse. It rises on the second rising clock edge after the edge that accepts the last sample of a group.
- R8: A change of `cfg_res16` or `cfg_avg_sel` discards the partial group. If a sample is accepted on the edge where the change is first seen, that sample starts the new group. The sample accepted one edge earlier is dropped.
- R9: With `cfg_cmp_en`=0, every group result is delivered and `cmp_hit` stays low.
- R10: Compare codes in `cfg_cmp_mode`: 0 passes when result < A. 1 passes when result >= A. 2 passes when A <= result <= B. 3 passes when result < A or result > B.
- R11: With `cfg_cmp_en`=1, a result that fails the compare gives no `res_vld` pulse, and `res_data` keeps its previous value.
- R12: With `cfg_cmp_en`=1, a passing result raises `cmp_hit` in the same cycle as `res_vld`. `cmp_hit` is never high without `res_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Raw code strobe |
| smp_code | input | 16 | Raw converter code |
| cfg_res16 | input | 1 | 1 selects 16-bit mode, 0 selects 12-bit mode |
| cfg_avg_sel | input | 3 | Group size code |
| cfg_cmp_en | input | 1 | Enables the automatic compare |
| cfg_cmp_mode | input | 2 | Compare condition code |
| cfg_thr_a | input | 16 | Threshold A |
| cfg_thr_b | input | 16 | Threshold B |
| cal_offset | input | 16 | Signed calibration offset |
| res_vld | output | 1 | Result strobe |
| res_data | output | 16 | Averaged result |
| cmp_hit | output | 1 | Result met the enabled compare |

## Verification
The riskiest coincidence is a group-size change that lands in the same cycle as a sample. On that edge the accumulator clear competes with the corrected sample leaving the first stage, and a new raw code is being accepted. The bench runs three samples of a four-sample group and then switches to eight samples on the same edge that carries the fourth code. It then expects exactly one result, equal to the rounded mean of that fourth code and the seven codes that follow. This shows that the in-flight sample was dropped and the accepted one was kept.

// File: rtl/sar_rp_pkg.sv
// Shared types and helpers for the conversion result path.
// Assumes group sizes are powers of two with log2 no larger than 5.
package sar_rp_pkg;

    typedef enum logic [1:0] {
        CMP_BELOW  = 2'd0,
        CMP_ATLEAST = 2'd1,
        CMP_INSIDE = 2'd2,
        CMP_OUTSIDE = 2'd3
    } cmp_mode_e;

    // Map the group-size select code to log2 of the group size.
    function automatic int unsigned avg_log2(input logic [2:0] sel);
        case (sel)
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 5;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sar_offset_corr.sv
// Offset correction stage: masks the raw code to the active resolution,
// subtracts a signed offset and clamps to [0, full scale].
// Assumes LOW_W < RAW_W. One register stage.
module sar_offset_corr #(
    parameter int RAW_W = 16,
    parameter int LOW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [RAW_W-1:0] in_code,
    input  logic             res16,
    input  logic [RAW_W-1:0] offset,
    output logic             out_vld,
    output logic [RAW_W-1:0] out_val
);
    localparam int DW = RAW_W + 2;
    localparam int PAD = RAW_W - LOW_W;

    logic [RAW_W-1:0]        code_m;
    logic [RAW_W-1:0]        full;
    logic signed [DW-1:0]    diff;
    logic [RAW_W-1:0]        clamped;

    // Mask the code, pick full scale and form the signed difference.
    always_comb begin
        code_m = res16 ? in_code : {{PAD{1'b0}}, in_code[LOW_W-1:0]};
        full   = res16 ? {RAW_W{1'b1}} : {{PAD{1'b0}}, {LOW_W{1'b1}}};
        diff   = $signed({2'b00, code_m}) - $signed({{2{offset[RAW_W-1]}}, offset});
    end

    // Clamp the difference at zero and at full scale.
    always_comb begin
        if (diff[DW-1]) begin
            clamped = '0;
        end else if (diff > $signed({2'b00, full})) begin
            clamped = full;
        end else begin
            clamped = diff[RAW_W-1:0];
        end
    end

    // Register the corrected sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_val <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_val <= clamped;
            end
        end
    end

endmodule

// File: rtl/sar_avg_accum.sv
// Group accumulator: sums 2**k corrected samples, then emits the rounded
// quotient (sum + half) >> k. A clear input drops the partial group and
// any sample arriving in the same cycle.
// Assumes MAX_LOG2 covers every shift the select code can produce.
module sar_avg_accum #(
    parameter int RAW_W    = 16,
    parameter int MAX_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_vld,
    input  logic [RAW_W-1:0] in_val,
    input  logic [2:0]       avg_sel,
    output logic             avg_vld,
    output logic [RAW_W-1:0] avg_val
);
    import sar_rp_pkg::*;

    localparam int ACC_W = RAW_W + MAX_LOG2;
    localparam int NCAND = MAX_LOG2 + 1;
    localparam int SH_W  = $clog2(NCAND);
    localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  shift;
    logic [CNT_W-1:0] cnt_lim;
    logic             last;
    logic [ACC_W-1:0] sum_next;
    logic [RAW_W-1:0] cand [NCAND];
    logic [RAW_W-1:0] pick;

    // Decode the select code into a shift, falling back to a group of one.
    always_comb begin
        shift = (avg_log2(avg_sel) > MAX_LOG2) ? '0 : SH_W'(avg_log2(avg_sel));
        cnt_lim = CNT_W'((32'd1 << shift) - 32'd1);
        last = (cnt_q == cnt_lim);
        sum_next = acc_q + ACC_W'(in_val);
    end

    // One rounded quotient per legal shift amount.
    generate
        for (genvar g = 0; g < NCAND; g++) begin : g_quot
            if (g == 0) begin : g_pass
                assign cand[g] = sum_next[RAW_W-1:0];
            end else begin : g_round
                logic [ACC_W-1:0] rnd;
                assign rnd     = sum_next + ACC_W'(1 << (g - 1));
                assign cand[g] = RAW_W'(rnd >> g);
            end
        end
    endgenerate

    // Select the quotient that matches the active shift.
    always_comb begin
        pick = cand[0];
        for (int i = 0; i < NCAND; i++) begin
            if (shift == SH_W'(i)) begin
                pick = cand[i];
            end
        end
    end

    // Accumulate, close groups and honour the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            avg_vld <= 1'b0;
            avg_val <= '0;
        end else if (clr) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            avg_vld <= 1'b0;
        end else if (in_vld) begin
            if (last) begin
                acc_q   <= '0;
                cnt_q   <= '0;
                avg_vld <= 1'b1;
                avg_val <= pick;
            end else begin
                acc_q   <= sum_next;
                cnt_q   <= cnt_q + CNT_W'(1);
                avg_vld <= 1'b0;
            end
        end else begin
            avg_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_cmp_gate.sv
// Threshold gate: evaluates the configured condition on each averaged
// value and delivers it, with a hit flag, or suppresses it.
// Assumes unsigned thresholds with A <= B for the range conditions.
module sar_cmp_gate #(
    parameter int RAW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [RAW_W-1:0] in_val,
    input  logic             cmp_en,
    input  logic [1:0]       cmp_mode,
    input  logic [RAW_W-1:0] thr_a,
    input  logic [RAW_W-1:0] thr_b,
    output logic             out_vld,
    output logic [RAW_W-1:0] out_val,
    output logic             hit
);
    import sar_rp_pkg::*;

    logic pass;
    logic deliver;

    // Evaluate the selected condition.
    always_comb begin
        case (cmp_mode_e'(cmp_mode))
            CMP_BELOW:   pass = (in_val < thr_a);
            CMP_ATLEAST: pass = (in_val >= thr_a);
            CMP_INSIDE:  pass = (in_val >= thr_a) && (in_val <= thr_b);
            default:     pass = (in_val < thr_a) || (in_val > thr_b);
        endcase
        deliver = in_vld && (!cmp_en || pass);
    end

    // Register the delivered result and the hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_val <= '0;
            hit     <= 1'b0;
        end else begin
            out_vld <= deliver;
            hit     <= in_vld && cmp_en && pass;
            if (deliver) begin
                out_val <= in_val;
            end
        end
    end

endmodule

// File: rtl/sar_result_path.sv
// Result path top: offset correction, group averaging and threshold
// gate in series. A change of resolution or group size clears the group.
// Assumes configuration inputs are synchronous to clk.
module sar_result_path #(
    parameter int RAW_W    = 16,
    parameter int LOW_W    = 12,
    parameter int MAX_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [RAW_W-1:0] smp_code,
    input  logic             cfg_res16,
    input  logic [2:0]       cfg_avg_sel,
    input  logic             cfg_cmp_en,
    input  logic [1:0]       cfg_cmp_mode,
    input  logic [RAW_W-1:0] cfg_thr_a,
    input  logic [RAW_W-1:0] cfg_thr_b,
    input  logic [RAW_W-1:0] cal_offset,
    output logic             res_vld,
    output logic [RAW_W-1:0] res_data,
    output logic             cmp_hit
);
    logic             res16_q;
    logic [2:0]       sel_q;
    logic             cfg_clr;
    logic             corr_vld;
    logic [RAW_W-1:0] corr_val;
    logic             avg_vld;
    logic [RAW_W-1:0] avg_val;

    // Remember the grouping configuration to spot changes.
    always_ff @(posedge clk) begin
        res16_q <= cfg_res16;
        sel_q   <= cfg_avg_sel;
    end

    // A differing setting restarts the group.
    assign cfg_clr = rst_n && ((cfg_res16 != res16_q) || (cfg_avg_sel != sel_q));

    sar_offset_corr #(
        .RAW_W (RAW_W),
        .LOW_W (LOW_W)
    ) u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (smp_vld),
        .in_code (smp_code),
        .res16   (cfg_res16),
        .offset  (cal_offset),
        .out_vld (corr_vld),
        .out_val (corr_val)
    );

    sar_avg_accum #(
        .RAW_W    (RAW_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_clr),
        .in_vld  (corr_vld),
        .in_val  (corr_val),
        .avg_sel (cfg_avg_sel),
        .avg_vld (avg_vld),
        .avg_val (avg_val)
    );

    sar_cmp_gate #(
        .RAW_W (RAW_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (avg_vld),
        .in_val   (avg_val),
        .cmp_en   (cfg_cmp_en),
        .cmp_mode (cfg_cmp_mode),
        .thr_a    (cfg_thr_a),
        .thr_b    (cfg_thr_b),
        .out_vld  (res_vld),
        .out_val  (res_data),
        .hit      (cmp_hit)
    );

endmodule

// File: rtl/sar_result_path_chk.sv
// Property checker for the result path, bound to the top module.
module sar_result_path_chk #(
    parameter int RAW_W = 16,
    parameter int LOW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_res16,
    input logic             cfg_cmp_en,
    input logic             avg_vld,
    input logic             res_vld,
    input logic [RAW_W-1:0] res_data,
    input logic             cmp_hit
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && !cmp_hit)); // R1

    AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !cfg_res16 && !$past(cfg_res16) && !$past(cfg_res16, 2))
        |-> (res_data[RAW_W-1:LOW_W] == '0)); // R2

    AST_VLD_FOLLOWS_AVG: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(avg_vld)); // R7

    AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !$past(cfg_cmp_en)) |-> !cmp_hit); // R9

    AST_HIT_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |-> res_vld); // R12

    AST_HIT_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(cfg_cmp_en)) |-> cmp_hit); // R12

endmodule

bind sar_result_path sar_result_path_chk #(
    .RAW_W (RAW_W),
    .LOW_W (LOW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_res16  (cfg_res16),
    .cfg_cmp_en (cfg_cmp_en),
    .avg_vld    (avg_vld),
    .res_vld    (res_vld),
    .res_data   (res_data),
    .cmp_hit    (cmp_hit)
);

// File: tb/tb_sar_result_path.sv
module tb_sar_result_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_code = '0;
    logic        cfg_res16 = 1'b1;
    logic [2:0]  cfg_avg_sel = '0;
    logic        cfg_cmp_en = 1'b0;
    logic [1:0]  cfg_cmp_mode = '0;
    logic [15:0] cfg_thr_a = '0;
    logic [15:0] cfg_thr_b = '0;
    logic [15:0] cal_offset = '0;
    logic        res_vld;
    logic [15:0] res_data;
    logic        cmp_hit;

    int n_chk = 0;
    int n_fail = 0;
    int got_n = 0;
    logic [15:0] got_d [0:63];
    logic        got_h [0:63];

    always #5 clk = ~clk;

    sar_result_path dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
        .cfg_res16(cfg_res16), .cfg_avg_sel(cfg_avg_sel), .cfg_cmp_en(cfg_cmp_en),
        .cfg_cmp_mode(cfg_cmp_mode), .cfg_thr_a(cfg_thr_a), .cfg_thr_b(cfg_thr_b),
        .cal_offset(cal_offset), .res_vld(res_vld), .res_data(res_data),
        .cmp_hit(cmp_hit)
    );

    // Collect every delivered result away from the active edge.
    always @(negedge clk) begin
        if (rst_n && res_vld && got_n < 64) begin
            got_d[got_n] = res_data;
            got_h[got_n] = cmp_hit;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic push(input logic [15:0] c);
        smp_code = c;
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic settle;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_count(input int n, input string req);
        chk(got_n == n, req, got_n, n);
    endtask

    task automatic expect_res(input int idx, input int d, input bit h, input string req);
        chk(got_d[idx] == 16'(d), req, int'(got_d[idx]), d);
        chk(got_h[idx] == h, req, int'(got_h[idx]), int'(h));
    endtask

    task automatic t_reset;
        chk(res_vld == 1'b0, "R1 vld", int'(res_vld), 0);
        chk(cmp_hit == 1'b0, "R1 hit", int'(cmp_hit), 0);
        chk(res_data == 16'd0, "R1 data", int'(res_data), 0);
    endtask

    task automatic t_passthrough;
        got_n = 0;
        push(16'd1000);
        push(16'hFFFF);
        settle();
        expect_count(2, "R5 R9 count");
        expect_res(0, 1000, 1'b0, "R9 first");
        expect_res(1, 65535, 1'b0, "R9 second");
    endtask

    task automatic t_offset;
        got_n = 0;
        cal_offset = 16'd100;
        push(16'd50);
        push(16'd300);
        cal_offset = 16'hFF38;
        push(16'd65500);
        settle();
        cfg_res16 = 1'b0;
        @(negedge clk);
        push(16'hFFA0);
        cal_offset = 16'd0;
        push(16'hA123);
        settle();
        expect_count(5, "R3 R4 count");
        expect_res(0, 0, 1'b0, "R3 clamp zero");
        expect_res(1, 200, 1'b0, "R3 subtract");
        expect_res(2, 65535, 1'b0, "R4 full scale 16");
        expect_res(3, 4095, 1'b0, "R4 R2 full scale 12");
        expect_res(4, 16'h0123, 1'b0, "R2 upper bits masked");
        cfg_res16 = 1'b1;
        settle();
    endtask

    task automatic t_average;
        got_n = 0;
        cfg_avg_sel = 3'd1;
        @(negedge clk);
        push(16'd10); push(16'd10); push(16'd11); push(16'd11);
        settle();
        cfg_avg_sel = 3'd2;
        @(negedge clk);
        for (int i = 0; i < 8; i++) push(16'(i));
        settle();
        cfg_avg_sel = 3'd3;
        @(negedge clk);
        for (int i = 0; i < 16; i++) push(16'd100);
        settle();
        cfg_avg_sel = 3'd4;
        @(negedge clk);
        for (int i = 0; i < 32; i++) push(16'(i));
        settle();
        cfg_avg_sel = 3'd5;
        @(negedge clk);
        push(16'd77);
        push(16'd78);
        settle();
        expect_count(6, "R5 group count");
        expect_res(0, 11, 1'b0, "R6 four samples");
        expect_res(1, 4, 1'b0, "R6 eight samples");
        expect_res(2, 100, 1'b0, "R5 sixteen samples");
        expect_res(3, 16, 1'b0, "R6 thirty-two samples");
        expect_res(4, 77, 1'b0, "R5 code five is one");
        expect_res(5, 78, 1'b0, "R5 code five second");
        cfg_avg_sel = 3'd0;
        settle();
    endtask

    task automatic t_cfg_change;
        got_n = 0;
        cfg_avg_sel = 3'd1;
        @(negedge clk);
        push(16'd1000); push(16'd1000); push(16'd1000);
        cfg_avg_sel = 3'd2;
        push(16'd1000);
        for (int i = 0; i < 7; i++) push(16'd8);
        settle();
        expect_count(1, "R8 same-cycle change count");
        expect_res(0, 132, 1'b0, "R8 same-cycle change value");
        got_n = 0;
        cfg_avg_sel = 3'd1;
        @(negedge clk);
        push(16'd4000); push(16'd4000); push(16'd4000);
        settle();
        cfg_res16 = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) push(16'd20);
        settle();
        expect_count(1, "R8 resolution change count");
        expect_res(0, 20, 1'b0, "R8 resolution change value");
        cfg_res16 = 1'b1;
        cfg_avg_sel = 3'd0;
        settle();
    endtask

    task automatic t_compare;
        cfg_cmp_en = 1'b1;
        cfg_thr_a = 16'd100;
        cfg_thr_b = 16'd200;
        got_n = 0;
        cfg_cmp_mode = 2'd0;
        push(16'd50); push(16'd150);
        settle();
        expect_count(1, "R10 R11 below count");
        expect_res(0, 50, 1'b1, "R10 R12 below");
        chk(res_data == 16'd50, "R11 data held", int'(res_data), 50);
        got_n = 0;
        cfg_cmp_mode = 2'd1;
        push(16'd50); push(16'd100);
        settle();
        expect_count(1, "R10 R11 at-least count");
        expect_res(0, 100, 1'b1, "R10 R12 at-least");
        got_n = 0;
        cfg_cmp_mode = 2'd2;
        push(16'd99); push(16'd100); push(16'd200); push(16'd201);
        settle();
        expect_count(2, "R10 inside count");
        expect_res(0, 100, 1'b1, "R10 inside low edge");
        expect_res(1, 200, 1'b1, "R10 inside high edge");
        got_n = 0;
        cfg_cmp_mode = 2'd3;
        push(16'd99); push(16'd100); push(16'd200); push(16'd201);
        settle();
        expect_count(2, "R10 outside count");
        expect_res(0, 99, 1'b1, "R10 outside low");
        expect_res(1, 201, 1'b1, "R10 outside high");
        cfg_cmp_en = 1'b0;
        settle();
    endtask

    task automatic t_latency;
        smp_code = 16'd555;
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        chk(res_vld == 1'b0, "R7 edge one", int'(res_vld), 0);
        @(negedge clk);
        chk(res_vld == 1'b0, "R7 edge two", int'(res_vld), 0);
        @(negedge clk);
        chk(res_vld == 1'b1, "R7 edge three", int'(res_vld), 1);
        chk(res_data == 16'd555, "R7 data", int'(res_data), 555);
        @(negedge clk);
        chk(res_vld == 1'b0, "R7 single pulse", int'(res_vld), 0);
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_offset();
        t_average();
        t_cfg_change();
        t_compare();
        t_latency();
        summary();
        $finish;
    end

endmodule